// File: doc/BRIEF.md
# Debug Hardware Command Executor

This block sits behind a debug serial front end. It takes hardware commands that have already been deserialized (an 8-bit opcode with a 16-bit address and a 16-bit data field) and runs each one. Memory commands become one cycle on a simple bus master port. That port raises a request, holds it until an arbiter grants it, and for reads takes the returned word in the cycle after the grant. Byte commands are steered onto the correct byte lane. Word commands are checked for alignment. Each bus cycle carries a flag that maps the debug-private registers over the application address space for that cycle only.

The block also keeps a handshake state. While the state is on, every command that finishes gives a one-cycle acknowledge pulse. A background-entry command is passed on to the core as a request. It is acted on only while the firmware-enable input is high, and it finishes when the core reports that background mode has been entered. While a command is in progress the block shows busy, and it ignores any command presented in that time.

Top module: `dbg_cmd_exec`

## Requirements
- R1: After reset, `cmd_busy`, `bus_req`, `bus_dbg_map`, `bg_req`, `rsp_ack`, `rsp_err` and `rsp_rdata` are all 0, and the handshake state is off.
- R2: Opcode 0xD5 turns the handshake on and pulses `rsp_ack` for one cycle in the cycle after it is accepted. Opcode 0xD6 turns the handshake off and gives no pulse. While the handshake is on, every command that completes pulses `rsp_ack` once, in its completion cycle. While it is off, no command pulses it, except 0xD5 itself.
- R3: Opcodes 0xE0 (byte) and 0xE8 (word) issue a bus read with `bus_dbg_map`=0. Opcodes 0xE4 (byte) and 0xEC (word) issue a bus read with `bus_dbg_map`=1. The returned data appears on `rsp_rdata` when the command completes.
- R4: Opcodes 0xC0 (byte) and 0xC8 (word) issue a bus write with `bus_dbg_map`=0. Opcodes 0xC4 (byte) and 0xCC (word) issue a bus write with `bus_dbg_map`=1. A write changes only the memory space that its flag selects.
- R5: A byte access to an odd address uses the low byte, data[7:0], with `bus_be`=01. A byte access to an even address uses the high byte, data[15:8], with `bus_be`=10. The unused lane is driven as zero in `bus_wdata` and in `rsp_rdata`.
- R6: A word access uses `bus_be`=11. A word access to an odd address issues no bus request. Instead it pulses `rsp_err` for one cycle in the cycle after acceptance, and it acknowledges in that same cycle if the handshake is on.
- R7: While `bus_req` is high and `bus_gnt` is low, the request, address, write data and byte enables stay unchanged. `bus_dbg_map` is never high while `bus_req` is low.
- R8: Opcode 0x90 with `fw_enable`=1 raises `bg_req` until `bg_entered` is seen. It then completes and acknowledges if the handshake is on. With `fw_enable`=0 the opcode raises no `bg_req` and gives no acknowledge.
- R9: Any opcode outside the set above gives no bus request, no `bg_req`, no `rsp_err` and no `rsp_ack`.
- R10: A command is accepted only when `cmd_valid` is high and `cmd_busy` is low. A command presented while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_enable | input | 1 | Firmware enable; background entry is allowed only while high |
| cmd_valid | input | 1 | Command fields are valid |
| cmd_opcode | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data for write commands |
| cmd_busy | output | 1 | A command is in progress; new commands are ignored |
| rsp_rdata | output | DATA_W | Data from the most recent completed read |
| rsp_ack | output | 1 | One-cycle acknowledge pulse |
| rsp_err | output | 1 | One-cycle pulse for a misaligned word access |
| bg_req | output | 1 | Request to the core to enter background mode |
| bg_entered | input | 1 | Core reports that background mode has been entered |
| bus_req | output | 1 | Bus cycle request, held until granted |
| bus_gnt | input | 1 | Arbiter grant; the cycle takes place when request and grant are both high |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Lane-steered write data |
| bus_be | output | DATA_W/8 | Byte enables; the top bit is the high byte |
| bus_dbg_map | output | 1 | Maps the debug registers in for this bus cycle |
| bus_rdata | input | DATA_W | Read data, valid in the cycle after the grant |

## Verification
Two sets of events can fall in the same cycle. The first is a handshake change together with an acknowledge decision: 0xD5 switches the handshake on and acknowledges itself in one step, while 0xD6 switches it off and stays silent. The bench provokes this by placing these opcodes directly before and after memory commands, then counts pulses over each command's window against a model of the handshake state.

The second is a new command arriving while an earlier one still waits for its grant. The bench holds the grant off, presents a second write during the busy window, then releases the grant. A later read shows that the second write left memory untouched.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam logic [7:0] OP_BKGND   = 8'h90;
  localparam logic [7:0] OP_HS_ON   = 8'hD5;
  localparam logic [7:0] OP_HS_OFF  = 8'hD6;
  localparam logic [7:0] OP_RD_B_OUT = 8'hE0;
  localparam logic [7:0] OP_RD_B_IN  = 8'hE4;
  localparam logic [7:0] OP_RD_W_OUT = 8'hE8;
  localparam logic [7:0] OP_RD_W_IN  = 8'hEC;
  localparam logic [7:0] OP_WR_B_OUT = 8'hC0;
  localparam logic [7:0] OP_WR_B_IN  = 8'hC4;
  localparam logic [7:0] OP_WR_W_OUT = 8'hC8;
  localparam logic [7:0] OP_WR_W_IN  = 8'hCC;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_HS_ON  = 3'd1,
    K_HS_OFF = 3'd2,
    K_BKGND  = 3'd3,
    K_READ   = 3'd4,
    K_WRITE  = 3'd5
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      word;
    logic      dbg_map;
  } cmd_dec_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_BUS    = 2'd1,
    S_RDWAIT = 2'd2,
    S_BKGND  = 2'd3
  } exec_state_e;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_dec_t   dec
);

  always_comb begin
    dec = '{kind: K_NONE, word: 1'b0, dbg_map: 1'b0};
    case (opcode)
      OP_BKGND:    dec.kind = K_BKGND;
      OP_HS_ON:    dec.kind = K_HS_ON;
      OP_HS_OFF:   dec.kind = K_HS_OFF;
      OP_RD_B_OUT: dec = '{kind: K_READ,  word: 1'b0, dbg_map: 1'b0};
      OP_RD_B_IN:  dec = '{kind: K_READ,  word: 1'b0, dbg_map: 1'b1};
      OP_RD_W_OUT: dec = '{kind: K_READ,  word: 1'b1, dbg_map: 1'b0};
      OP_RD_W_IN:  dec = '{kind: K_READ,  word: 1'b1, dbg_map: 1'b1};
      OP_WR_B_OUT: dec = '{kind: K_WRITE, word: 1'b0, dbg_map: 1'b0};
      OP_WR_B_IN:  dec = '{kind: K_WRITE, word: 1'b0, dbg_map: 1'b1};
      OP_WR_W_OUT: dec = '{kind: K_WRITE, word: 1'b1, dbg_map: 1'b0};
      OP_WR_W_IN:  dec = '{kind: K_WRITE, word: 1'b1, dbg_map: 1'b1};
      default:     dec = '{kind: K_NONE,  word: 1'b0, dbg_map: 1'b0};
    endcase
  end

endmodule

// File: rtl/dbg_lane_steer.sv
module dbg_lane_steer #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              is_word,
  input  logic [OFS_W-1:0]  addr_ofs,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [LANES-1:0]  rd_be,
  input  logic [DATA_W-1:0] rd_raw,
  output logic [LANES-1:0]  be_out,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rd_out,
  output logic              misaligned
);

  // Byte at offset 0 sits in the most significant lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(LANES - 1 - g);
    logic sel;
    assign sel                 = is_word || (addr_ofs == LANE_OFS);
    assign be_out[g]           = sel;
    assign wdata_out[g*8 +: 8] = sel ? wdata_in[g*8 +: 8] : 8'h00;
    assign rd_out[g*8 +: 8]    = rd_be[g] ? rd_raw[g*8 +: 8] : 8'h00;
  end

  assign misaligned = is_word && (addr_ofs != '0);

endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
  import dbg_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fw_enable,
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_opcode,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]   cmd_wdata,
  output logic                cmd_busy,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_ack,
  output logic                rsp_err,
  output logic                bg_req,
  input  logic                bg_entered,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W/8-1:0] bus_be,
  output logic                bus_dbg_map,
  input  logic [DATA_W-1:0]   bus_rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;

  exec_state_e         state;
  logic                hs_on;
  cmd_dec_t            dec;
  logic                accept;
  logic [LANES-1:0]    st_be;
  logic [DATA_W-1:0]   st_wdata;
  logic [DATA_W-1:0]   st_rdata;
  logic                st_misaligned;

  dbg_cmd_decode u_decode (
    .opcode (cmd_opcode),
    .dec    (dec)
  );

  dbg_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .is_word    (dec.word),
    .addr_ofs   (cmd_addr[OFS_W-1:0]),
    .wdata_in   (cmd_wdata),
    .rd_be      (bus_be),
    .rd_raw     (bus_rdata),
    .be_out     (st_be),
    .wdata_out  (st_wdata),
    .rd_out     (st_rdata),
    .misaligned (st_misaligned)
  );

  assign cmd_busy = (state != S_IDLE);
  assign accept   = cmd_valid && !cmd_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      hs_on       <= 1'b0;
      rsp_rdata   <= '0;
      rsp_ack     <= 1'b0;
      rsp_err     <= 1'b0;
      bg_req      <= 1'b0;
      bus_req     <= 1'b0;
      bus_we      <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_be      <= '0;
      bus_dbg_map <= 1'b0;
    end else begin
      rsp_ack <= 1'b0;
      rsp_err <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            case (dec.kind)
              K_HS_ON: begin
                hs_on   <= 1'b1;
                rsp_ack <= 1'b1;
              end
              K_HS_OFF: hs_on <= 1'b0;
              K_BKGND: begin
                if (fw_enable) begin
                  bg_req <= 1'b1;
                  state  <= S_BKGND;
                end
              end
              K_READ, K_WRITE: begin
                if (st_misaligned) begin
                  rsp_err <= 1'b1;
                  rsp_ack <= hs_on;
                end else begin
                  bus_req     <= 1'b1;
                  bus_we      <= (dec.kind == K_WRITE);
                  bus_addr    <= cmd_addr;
                  bus_wdata   <= (dec.kind == K_WRITE) ? st_wdata : '0;
                  bus_be      <= st_be;
                  bus_dbg_map <= dec.dbg_map;
                  state       <= S_BUS;
                end
              end
              default: ;
            endcase
          end
        end
        S_BUS: begin
          if (bus_gnt) begin
            bus_req     <= 1'b0;
            bus_dbg_map <= 1'b0;
            if (bus_we) begin
              rsp_ack <= hs_on;
              state   <= S_IDLE;
            end else begin
              state <= S_RDWAIT;
            end
          end
        end
        S_RDWAIT: begin
          rsp_rdata <= st_rdata;
          rsp_ack   <= hs_on;
          state     <= S_IDLE;
        end
        S_BKGND: begin
          if (bg_entered) begin
            bg_req  <= 1'b0;
            rsp_ack <= hs_on;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dbg_cmd_exec_chk.sv
module dbg_cmd_exec_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                fw_enable,
  input logic                cmd_valid,
  input logic                cmd_busy,
  input logic [7:0]          cmd_opcode,
  input logic                cmd_lsb,
  input logic                rsp_ack,
  input logic                rsp_err,
  input logic                bg_req,
  input logic                bus_req,
  input logic                bus_gnt,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W/8-1:0] bus_be,
  input logic                bus_dbg_map
);

  logic take;
  logic known;
  logic is_wordop;
  assign take      = cmd_valid && !cmd_busy;
  assign is_wordop = (cmd_opcode == 8'hE8) || (cmd_opcode == 8'hEC) ||
                     (cmd_opcode == 8'hC8) || (cmd_opcode == 8'hCC);
  assign known     = is_wordop || (cmd_opcode == 8'h90) || (cmd_opcode == 8'hD5) ||
                     (cmd_opcode == 8'hD6) || (cmd_opcode == 8'hE0) || (cmd_opcode == 8'hE4) ||
                     (cmd_opcode == 8'hC0) || (cmd_opcode == 8'hC4);

  // R2
  a_r2_hs_on_acks: assert property (@(posedge clk) disable iff (rst)
    take && cmd_opcode == 8'hD5 |=> rsp_ack);
  a_r2_hs_off_silent: assert property (@(posedge clk) disable iff (rst)
    take && cmd_opcode == 8'hD6 |=> !rsp_ack);
  // R5
  a_r5_byte_lane: assert property (@(posedge clk) disable iff (rst)
    bus_req && $countones(bus_be) == 1 |-> bus_be[0] == bus_addr[0]);
  // R6
  a_r6_misaligned: assert property (@(posedge clk) disable iff (rst)
    take && is_wordop && cmd_lsb |=> rsp_err && !bus_req);
  a_r6_word_aligned: assert property (@(posedge clk) disable iff (rst)
    bus_req && $countones(bus_be) > 1 |-> !bus_addr[0]);
  // R7
  a_r7_hold_req: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_be));
  a_r7_map_only_in_cycle: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> !bus_dbg_map);
  // R8
  a_r8_fw_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(bg_req) |-> $past(fw_enable));
  // R9
  a_r9_unknown_ignored: assert property (@(posedge clk) disable iff (rst)
    take && !known |=> !rsp_ack && !rsp_err && !bus_req && !bg_req);

endmodule

bind dbg_cmd_exec dbg_cmd_exec_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fw_enable   (fw_enable),
  .cmd_valid   (cmd_valid),
  .cmd_busy    (cmd_busy),
  .cmd_opcode  (cmd_opcode),
  .cmd_lsb     (cmd_addr[0]),
  .rsp_ack     (rsp_ack),
  .rsp_err     (rsp_err),
  .bg_req      (bg_req),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_be      (bus_be),
  .bus_dbg_map (bus_dbg_map)
);

// File: tb/tb_dbg_cmd_exec.sv
module tb_dbg_cmd_exec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fw_enable = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [15:0] cmd_addr = 16'h0;
  logic [15:0] cmd_wdata = 16'h0;
  logic        cmd_busy;
  logic [15:0] rsp_rdata;
  logic        rsp_ack, rsp_err, bg_req;
  logic        bg_entered = 1'b0;
  logic        bus_req, bus_we, bus_dbg_map;
  logic        bus_gnt = 1'b0;
  logic [15:0] bus_addr, bus_wdata;
  logic [1:0]  bus_be;
  logic [15:0] bus_rdata = 16'h0;

  always #2.5 clk = ~clk;

  dbg_cmd_exec dut (
    .clk(clk), .rst(rst), .fw_enable(fw_enable),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_busy(cmd_busy), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
    .bg_req(bg_req), .bg_entered(bg_entered),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_dbg_map(bus_dbg_map), .bus_rdata(bus_rdata)
  );

  // Memory system: application space and debug overlay space.
  logic [15:0] mem_app [256];
  logic [15:0] mem_dbg [256];
  logic [15:0] ref_app [256];
  logic [15:0] ref_dbg [256];
  bit          hold_gnt = 1'b0;

  always @(posedge clk) begin
    if (bus_req && bus_gnt) begin
      if (bus_we) begin
        if (bus_dbg_map) begin
          if (bus_be[1]) mem_dbg[bus_addr[8:1]][15:8] <= bus_wdata[15:8];
          if (bus_be[0]) mem_dbg[bus_addr[8:1]][7:0]  <= bus_wdata[7:0];
        end else begin
          if (bus_be[1]) mem_app[bus_addr[8:1]][15:8] <= bus_wdata[15:8];
          if (bus_be[0]) mem_app[bus_addr[8:1]][7:0]  <= bus_wdata[7:0];
        end
      end else begin
        bus_rdata <= bus_dbg_map ? mem_dbg[bus_addr[8:1]] : mem_app[bus_addr[8:1]];
      end
    end
  end

  always @(negedge clk) begin
    bus_gnt    <= !hold_gnt && bus_req && ($urandom_range(0, 2) == 0);
    bg_entered <= bg_req && ($urandom_range(0, 1) == 0);
  end

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  bit  m_hs = 1'b0;

  int          o_ack, o_err;
  bit          o_req, o_bg, o_map;
  logic [1:0]  o_be;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input bit map, input logic [15:0] a, input bit word);
    logic [15:0] w;
    w = map ? ref_dbg[a[8:1]] : ref_app[a[8:1]];
    if (word) return w;
    return a[0] ? {8'h00, w[7:0]} : {w[15:8], 8'h00};
  endfunction

  task automatic issue(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    while (cmd_busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_addr = a; cmd_wdata = d;
    o_ack = 0; o_err = 0; o_req = 0; o_bg = 0; o_map = 0; o_be = 2'b00;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (rsp_ack) o_ack++;
      if (rsp_err) o_err++;
      if (bg_req) o_bg = 1;
      if (bus_req) begin o_req = 1; o_map = bus_dbg_map; o_be = bus_be; end
      if (!cmd_busy) break;
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d);
    bit is_rd, is_wr, word, map, bad, e_req, e_bg, e_err;
    int e_ack;
    logic [1:0]  e_be;
    logic [15:0] e_rd;
    is_rd = (op == 8'hE0) || (op == 8'hE4) || (op == 8'hE8) || (op == 8'hEC);
    is_wr = (op == 8'hC0) || (op == 8'hC4) || (op == 8'hC8) || (op == 8'hCC);
    word  = op[3];
    map   = op[2];
    bad   = (is_rd || is_wr) && word && a[0];
    e_req = (is_rd || is_wr) && !bad;
    e_err = bad;
    e_bg  = (op == 8'h90) && fw_enable;
    e_ack = 0;
    e_be  = word ? 2'b11 : (a[0] ? 2'b01 : 2'b10);
    e_rd  = exp_read(map, a, word);
    if (op == 8'hD5) e_ack = 1;
    else if (e_req || e_err || e_bg) e_ack = m_hs ? 1 : 0;
    issue(op, a, d);
    if (op == 8'hD5) m_hs = 1;
    if (op == 8'hD6) m_hs = 0;
    chk(o_ack == e_ack, $sformatf("R2 ack count op=%0h", op), o_ack, e_ack);
    chk(o_err == (e_err ? 1 : 0), $sformatf("R6 err op=%0h", op), o_err, e_err);
    chk(o_req == e_req, $sformatf("R9 bus request op=%0h", op), o_req, e_req);
    chk(o_bg == e_bg, $sformatf("R8 bg_req op=%0h", op), o_bg, e_bg);
    if (e_req) begin
      chk(o_map == map, $sformatf("R3 R4 overlay flag op=%0h", op), o_map, map);
      chk(o_be == e_be, $sformatf("R5 byte enables op=%0h a=%0h", op, a), o_be, e_be);
    end
    if (e_req && is_rd)
      chk(rsp_rdata == e_rd, $sformatf("R3 R5 read data op=%0h a=%0h", op, a), rsp_rdata, e_rd);
    if (e_req && is_wr) begin
      if (word || !a[0]) begin
        if (map) ref_dbg[a[8:1]][15:8] = d[15:8]; else ref_app[a[8:1]][15:8] = d[15:8];
      end
      if (word || a[0]) begin
        if (map) ref_dbg[a[8:1]][7:0] = d[7:0]; else ref_app[a[8:1]][7:0] = d[7:0];
      end
    end
  endtask

  logic [7:0] op_set [14] = '{8'h90, 8'hD5, 8'hD6, 8'hE0, 8'hE4, 8'hE8, 8'hEC,
                              8'hC0, 8'hC4, 8'hC8, 8'hCC, 8'h55, 8'hA7, 8'hE1};

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem_app[i] = 16'($urandom); mem_dbg[i] = 16'($urandom);
      ref_app[i] = mem_app[i];    ref_dbg[i] = mem_dbg[i];
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_busy && !bus_req && !bus_dbg_map && !bg_req && !rsp_ack && !rsp_err,
        "R1 control outputs after reset", {cmd_busy, bus_req, bus_dbg_map, bg_req, rsp_ack, rsp_err}, 0);
    chk(rsp_rdata == 16'h0, "R1 read data after reset", rsp_rdata, 0);
    // R1 R2: handshake off after reset, so a read gives no ack
    run(8'hE8, 16'h0010, 16'h0);
    run(8'hD6, 16'h0, 16'h0);
    run(8'hD5, 16'h0, 16'h0);
    // R4 overlay: write debug space, application space unchanged
    run(8'hCC, 16'h0020, 16'hBEEF);
    run(8'hE8, 16'h0020, 16'h0);
    run(8'hEC, 16'h0020, 16'h0);
    // R5 byte lanes, both parities, both spaces
    run(8'hC0, 16'h0031, 16'h12A5);
    run(8'hC4, 16'h0030, 16'h7E34);
    run(8'hE0, 16'h0031, 16'h0);
    run(8'hE4, 16'h0030, 16'h0);
    run(8'hC8, 16'h0040, 16'hCAFE);
    run(8'hE8, 16'h0040, 16'h0);
    // R6 misaligned words with handshake on and off
    run(8'hEC, 16'h0043, 16'h0);
    run(8'hC8, 16'h0045, 16'h1111);
    run(8'hE8, 16'h0044, 16'h0);
    run(8'hD6, 16'h0, 16'h0);
    run(8'hCC, 16'h0047, 16'h2222);
    // R8 background gated by firmware enable
    fw_enable = 1'b0; run(8'h90, 16'h0, 16'h0);
    fw_enable = 1'b1; run(8'h90, 16'h0, 16'h0);
    run(8'hD5, 16'h0, 16'h0);
    run(8'h90, 16'h0, 16'h0);
    fw_enable = 1'b0; run(8'h90, 16'h0, 16'h0);
    // R9 unknown opcodes
    run(8'h55, 16'h0050, 16'h0);
    run(8'hFF, 16'h0051, 16'h0);
    // R10 command presented while busy is dropped
    hold_gnt = 1'b1;
    @(negedge clk);
    while (cmd_busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = 8'hC8; cmd_addr = 16'h0060; cmd_wdata = 16'hA1A2;
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    chk(cmd_busy == 1'b1, "R10 busy while waiting for grant", cmd_busy, 1);
    cmd_valid = 1'b1; cmd_opcode = 8'hC8; cmd_addr = 16'h0062; cmd_wdata = 16'h5A5A;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_addr == 16'h0060, "R10 R7 pending address held", bus_addr, 16'h0060);
    hold_gnt = 1'b0;
    while (cmd_busy) @(negedge clk);
    ref_app[8'h30] = 16'hA1A2;
    run(8'hE8, 16'h0060, 16'h0);
    run(8'hE8, 16'h0062, 16'h0);
    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0]  op;
      logic [15:0] a;
      op = op_set[$urandom_range(0, 13)];
      a  = 16'($urandom_range(0, 511));
      fw_enable = ($urandom_range(0, 1) == 1);
      run(op, a, 16'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule